// File: doc/BRIEF.md
# Pixel-Spacing Line Generator

This block draws a straight line or a circular arc into a raster scan without any multiplier and without a frame buffer. The raster is treated as one long run of linear positions, position = row × width + column, visited one per clock. A line is then just a series of lit positions separated by a nearly constant gap. That gap is the screen width plus a signed slope term, and the slope term may carry a fraction. A down counter measures each gap. When it reaches zero the block raises a one-cycle strobe, and the counter is reloaded with the next gap.

A frame-start pulse arms the block and captures all of its inputs. These are the first lit position, the signed fixed-point slope, an arc enable with its per-pixel slope step, and the number of pixels to draw. The fractional part of the slope builds up in an accumulator. Each time that accumulator overflows, one extra position is added to the next gap. In arc mode the step is added to the slope after every lit pixel, so the gap bends steadily; the size of the step sets how tightly the arc curves. The slope is held within ±1, because steeper lines fall outside this gap-counting method.

Top module: `lpx_line_gen`

## Requirements
- R1: While reset is high and after it, until the first frame start, `pix_on` stays low.
- R2: A frame start is sampled on a rising clock edge. The strobe for linear position p is then high for exactly the one cycle that follows the (p+1)-th rising edge after that sampling edge. The first lit position is `start_pos`.
- R3: `slope` and `arc_step` are two's complement with FRAC_W fraction bits, so the value is code/2^FRAC_W. With integer slopes the gap between lit positions is W+m. A slope of 0 gives W (a vertical line), a code of +2^FRAC_W gives W+1, and a code of −2^FRAC_W gives W−1.
- R4: A fraction accumulator starts at zero on each frame. For each gap, t = W·2^FRAC_W + m + acc. The gap is then floor(t / 2^FRAC_W), and acc becomes t mod 2^FRAC_W.
- R5: With `arc_en` high at frame start, the slope grows by `arc_step` after every lit pixel.
- R6: The working slope is held within [−2^FRAC_W, +2^FRAC_W]. This applies both to the value loaded at frame start and to every arc step.
- R7: At most `pix_count` pixels are lit per frame. A count of zero lights none.
- R8: No position at or beyond W·H is lit. A `start_pos` at or past the end of the frame lights nothing.
- R9: A frame start abandons any drawing in progress. The cycle after its sampling edge has `pix_on` low, and then the new frame begins.
- R10: `start_pos`, `slope`, `arc_en`, `arc_step` and `pix_count` are used only at the frame-start edge. Changing them during a frame does not alter that frame's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one linear position per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Arms a new frame and captures the other inputs |
| start_pos | input | POS_W | Linear position of the first pixel |
| slope | input | FRAC_W+2 | Signed fixed-point slope term m |
| arc_en | input | 1 | Selects arc mode (slope stepped per pixel) |
| arc_step | input | FRAC_W+2 | Signed fixed-point slope increment for arcs |
| pix_count | input | CNT_W | Number of pixels to draw |
| pix_on | output | 1 | Registered pixel-on strobe |

## Verification
The embedded properties hold on every cycle. They check that reset and frame start both force the strobe low, and that an exhausted pixel budget keeps it low. They also check that every reloaded gap lies between W−1 and W+1, that the working slope never leaves ±1, and that the frame window closes after the last position. Only the bench's scenarios can show the exact placement of each lit position. This covers integer spacing for vertical and diagonal lines, the carry timing of fractional slopes, the bending of arcs and their saturation, the cut-off at the end of the frame, restarts part way through a frame, and the fact that inputs changed mid-frame are ignored. Those results come from comparing the strobe cycle by cycle against a behavioural model of the position series.

// File: rtl/lpx_pkg.sv
package lpx_pkg;
  typedef enum logic {
    TRACE_LINE = 1'b0,
    TRACE_ARC  = 1'b1
  } trace_e;
endpackage

// File: rtl/lpx_spacing.sv
// Gap to the next lit position, with fractional carry folded into the sum.
module lpx_spacing #(
  parameter int SCR_W   = 16,
  parameter int FRAC_W  = 4,
  parameter int SLOPE_W = FRAC_W + 2,
  parameter int GAP_W   = 5
) (
  input  logic [SLOPE_W-1:0] slope_cur,
  input  logic [FRAC_W-1:0]  acc_cur,
  output logic [GAP_W-1:0]   gap,
  output logic [FRAC_W-1:0]  acc_next
);
  localparam int SUM_W = GAP_W + FRAC_W;

  logic [SUM_W-1:0] base_term, slope_term, acc_term, total;

  assign base_term  = SUM_W'(SCR_W) << FRAC_W;
  assign slope_term = {{(SUM_W-SLOPE_W){slope_cur[SLOPE_W-1]}}, slope_cur};
  assign acc_term   = {{(SUM_W-FRAC_W){1'b0}}, acc_cur};
  assign total      = base_term + slope_term + acc_term;
  assign gap        = total[SUM_W-1:FRAC_W];
  assign acc_next   = total[FRAC_W-1:0];
endmodule

// File: rtl/lpx_slope.sv
// Working slope register: loaded at frame start, stepped in arc mode, held within +/-1.
module lpx_slope #(
  parameter int FRAC_W  = 4,
  parameter int SLOPE_W = FRAC_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [SLOPE_W-1:0] load_val,
  input  logic               step_en,
  input  logic [SLOPE_W-1:0] step_val,
  output logic [SLOPE_W-1:0] slope_cur
);
  localparam int ONE = 2 ** FRAC_W;
  localparam logic signed [SLOPE_W:0]   LIM_HI = (SLOPE_W+1)'(ONE);
  localparam logic signed [SLOPE_W:0]   LIM_LO = -LIM_HI;
  localparam logic signed [SLOPE_W-1:0] M_MAX  = SLOPE_W'(ONE);
  localparam logic signed [SLOPE_W-1:0] M_MIN  = -M_MAX;

  logic signed [SLOPE_W-1:0] m_q;
  logic signed [SLOPE_W:0]   load_ext, stepped;

  function automatic logic signed [SLOPE_W-1:0] sat(input logic signed [SLOPE_W:0] v);
    if (v > LIM_HI)      sat = M_MAX;
    else if (v < LIM_LO) sat = M_MIN;
    else                 sat = v[SLOPE_W-1:0];
  endfunction

  assign load_ext = $signed({load_val[SLOPE_W-1], load_val});
  assign stepped  = $signed({m_q[SLOPE_W-1], m_q}) + $signed({step_val[SLOPE_W-1], step_val});

  always_ff @(posedge clk) begin
    if (rst)          m_q <= '0;
    else if (load)    m_q <= sat(load_ext);
    else if (step_en) m_q <= sat(stepped);
  end

  assign slope_cur = m_q;

  // R6
  slope_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (m_q >= M_MIN) && (m_q <= M_MAX));
endmodule

// File: rtl/lpx_frame_pos.sv
// Linear position tracker: opens a window at frame start, closes it after the last position.
module lpx_frame_pos #(
  parameter int NPIX  = 192,
  parameter int POS_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic in_frame
);
  localparam logic [POS_W-1:0] LAST = POS_W'(NPIX - 1);

  logic [POS_W-1:0] pos_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      open_q <= 1'b0;
    end else if (restart) begin
      pos_q  <= '0;
      open_q <= 1'b1;
    end else if (open_q) begin
      if (pos_q == LAST) open_q <= 1'b0;
      else               pos_q  <= pos_q + POS_W'(1);
    end
  end

  assign in_frame = open_q;

  // R8
  frame_close_chk: assert property (@(posedge clk) disable iff (rst)
    (open_q && !restart && pos_q == LAST) |=> !open_q);
endmodule

// File: rtl/lpx_line_gen.sv
module lpx_line_gen #(
  parameter int SCR_W  = 16,
  parameter int SCR_H  = 12,
  parameter int FRAC_W = 4,
  localparam int NPIX    = SCR_W * SCR_H,
  localparam int POS_W   = $clog2(NPIX),
  localparam int CNT_W   = $clog2(NPIX + 1),
  localparam int SLOPE_W = FRAC_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               frame_start,
  input  logic [POS_W-1:0]   start_pos,
  input  logic [SLOPE_W-1:0] slope,
  input  logic               arc_en,
  input  logic [SLOPE_W-1:0] arc_step,
  input  logic [CNT_W-1:0]   pix_count,
  output logic               pix_on
);
  import lpx_pkg::*;

  localparam int GAP_W = $clog2(SCR_W + 2);

  logic [POS_W-1:0]   gap_cnt;
  logic [CNT_W-1:0]   left_q;
  logic [FRAC_W-1:0]  acc_q, acc_next;
  logic [SLOPE_W-1:0] step_q, slope_cur;
  logic [GAP_W-1:0]   gap;
  trace_e             mode_q;
  logic               in_frame, hit;

  lpx_frame_pos #(.NPIX(NPIX), .POS_W(POS_W)) u_pos (
    .clk(clk), .rst(rst), .restart(frame_start), .in_frame(in_frame));

  lpx_slope #(.FRAC_W(FRAC_W), .SLOPE_W(SLOPE_W)) u_slope (
    .clk(clk), .rst(rst), .load(frame_start), .load_val(slope),
    .step_en(hit && mode_q == TRACE_ARC), .step_val(step_q),
    .slope_cur(slope_cur));

  lpx_spacing #(.SCR_W(SCR_W), .FRAC_W(FRAC_W), .SLOPE_W(SLOPE_W), .GAP_W(GAP_W)) u_gap (
    .slope_cur(slope_cur), .acc_cur(acc_q), .gap(gap), .acc_next(acc_next));

  assign hit = in_frame && (left_q != '0) && (gap_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_on  <= 1'b0;
      gap_cnt <= '0;
      left_q  <= '0;
      acc_q   <= '0;
      step_q  <= '0;
      mode_q  <= TRACE_LINE;
    end else if (frame_start) begin
      pix_on  <= 1'b0;
      gap_cnt <= start_pos;
      left_q  <= pix_count;
      acc_q   <= '0;
      step_q  <= arc_step;
      mode_q  <= arc_en ? TRACE_ARC : TRACE_LINE;
    end else begin
      pix_on <= hit;
      if (hit) begin
        left_q  <= left_q - CNT_W'(1);
        gap_cnt <= POS_W'(gap) - POS_W'(1);
        acc_q   <= acc_next;
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - POS_W'(1);
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !pix_on);

  // R9
  restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !pix_on);

  // R7
  budget_spent_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && left_q == '0) |=> !pix_on);

  // R3
  gap_range_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (gap >= GAP_W'(SCR_W - 1) && gap <= GAP_W'(SCR_W + 1)));
endmodule

// File: tb/test_lpx_line_gen.sv
module test_lpx_line_gen;
  localparam int SW = 16, SH = 12, FW = 4;
  localparam int NP = SW * SH;
  localparam int PW = $clog2(NP), CW = $clog2(NP + 1), MW = FW + 2;
  localparam int ONE = 1 << FW;

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, arc_en = 1'b0;
  logic [PW-1:0] start_pos = '0;
  logic [MW-1:0] slope = '0, arc_step = '0;
  logic [CW-1:0] pix_count = '0;
  logic pix_on;

  always #10 clk = ~clk;

  lpx_line_gen #(.SCR_W(SW), .SCR_H(SH), .FRAC_W(FW)) i_lpx_line_gen (
    .clk(clk), .rst(rst), .frame_start(frame_start), .start_pos(start_pos),
    .slope(slope), .arc_en(arc_en), .arc_step(arc_step),
    .pix_count(pix_count), .pix_on(pix_on));

  int total = 0, bad = 0;
  int rel = -1;
  int seen = 0, exp_pulses = 0, next_pulses = 0;
  bit exp_map[NP];
  bit next_map[NP];
  string tag = "R1";

  function automatic int clamp1(int v);
    if (v > ONE) return ONE;
    if (v < -ONE) return -ONE;
    return v;
  endfunction

  task automatic build(int sp, int m, bit arc, int st, int cnt);
    int p = sp, acc = 0, k = 0, t;
    m = clamp1(m);
    for (int i = 0; i < NP; i++) next_map[i] = 1'b0;
    while (k < cnt && p < NP) begin
      next_map[p] = 1'b1;
      k++;
      t = SW * ONE + m + acc;
      p = p + t / ONE;
      acc = t % ONE;
      if (arc) m = clamp1(m + st);
    end
    next_pulses = k;
  endtask

  task automatic launch(int sp, int m, bit arc, int st, int cnt, string t);
    build(sp, m, arc, st, cnt);
    @(posedge clk); #1;
    start_pos = PW'(sp); slope = MW'(m); arc_en = arc;
    arc_step = MW'(st); pix_count = CW'(cnt);
    frame_start = 1'b1;
    tag = t;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic count_check(string t);
    total++;
    if (seen != exp_pulses) begin
      bad++;
      $display("FAIL %s pixel count actual=%0d expected=%0d", t, seen, exp_pulses);
    end
  endtask

  task automatic run_frame(int sp, int m, bit arc, int st, int cnt, string t);
    launch(sp, m, arc, st, cnt, t);
    repeat (NP + 4) @(posedge clk);
    count_check(t);
  endtask

  always @(posedge clk) begin
    if (rst) rel <= -1;
    else if (frame_start) begin
      rel <= 0;
      exp_map <= next_map;
      exp_pulses <= next_pulses;
    end else if (rel >= 0 && rel < NP + 8) rel <= rel + 1;
  end

  always @(negedge clk) begin
    bit e;
    e = (rel >= 1 && rel <= NP) ? exp_map[rel-1] : 1'b0;
    total++;
    if (pix_on !== e) begin
      bad++;
      $display("FAIL %s rel=%0d pix_on actual=%b expected=%b", tag, rel, pix_on, e);
    end
    if (rel == 0) seen = 0;
    else if (pix_on === 1'b1) seen++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    repeat (5) @(posedge clk);           // R1: idle, monitor expects low
    run_frame(3, 0, 0, 0, 6, "R2_R3_vertical");
    run_frame(0, 0, 0, 0, 1, "R2_first_at_zero");
    run_frame(5, ONE, 0, 0, 20, "R3_R8_diag_pos");
    run_frame(20, -ONE, 0, 0, 6, "R3_diag_neg");
    run_frame(0, ONE / 2, 0, 0, 11, "R4_half");
    run_frame(7, -5, 0, 0, 11, "R4_neg_frac");
    run_frame(1, -ONE, 1, 3, 12, "R5_arc");
    run_frame(2, 12, 1, 8, 12, "R6_arc_sat");
    run_frame(4, 31, 0, 0, 8, "R6_load_sat");
    run_frame(4, -32, 1, -2, 8, "R6_load_sat_neg");
    run_frame(9, 0, 0, 0, 0, "R7_zero");
    run_frame(2, 3, 0, 0, 3, "R7_budget");
    run_frame(NP - 1, 0, 0, 0, 4, "R8_last_pos");
    run_frame(200, 0, 0, 0, 4, "R8_beyond");
    // R9: restart part-way through a frame
    launch(0, ONE, 0, 0, 20, "R9_first");
    repeat (40) @(posedge clk);
    run_frame(6, -3, 0, 0, 9, "R9_restart");
    // R10: inputs changed mid-frame are ignored
    launch(5, 6, 1, 2, 9, "R10_hold");
    repeat (30) @(posedge clk);
    #1;
    start_pos = PW'(0); slope = MW'(-ONE); arc_en = 1'b0;
    arc_step = MW'(0); pix_count = CW'(1);
    repeat (NP) @(posedge clk);
    count_check("R10_hold");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule